// File: doc/BRIEF.md
# Address-Matched Write Fault Injector

This block sits on the write path of a memory controller, after the check-bit encoder and before the memory interface. Each transaction carries its decoded location: a module number counted within its channel, a rank, a channel, a bank, a page and a column. The block compares these six fields against programmed match values. Any field can instead hold a wildcard that accepts every value. When injection is armed and a write matches on every field, the block can flip chosen check bits in the low half, the high half or both halves of the two-section codeword. It can also raise a parity-error flag that travels with the transaction.

Software programs the block through a plain register write port. Every register can be read back through a combinational read port. A type word selects one-shot or repeated injection and picks check-bit corruption, parity corruption or both. An injection counter and a one-cycle pulse output let a verification environment confirm that exactly the intended writes were corrupted. Transactions pass through one register stage, and data bits are never altered.

Top module: `wr_fault_injector`

## Requirements
- R1: The six location fields are compared independently. A transaction can be corrupted only if it is a write and every field that is not a wildcard equals the matching location input. Reads and non-matching writes leave the block unchanged.
- R2: The match registers sit at addresses 0 to 5 in this order: module, rank, channel, bank, page, column. A write with bit 31 set makes the field a wildcard. A write with bit 31 clear stores the low bits as the value and clears the wildcard. A read returns the wildcard flag in bit 31 and the stored value in the low bits. After reset, every field reads 0x80000000.
- R3: When type bit 1 is set, an injection XORs the mask register (address 6) into the check bits of each selected section. Data bits are never changed.
- R4: The section register (address 7) uses bit 0 for the low check half, `in_chk[CHK_W-1:0]`, and bit 1 for the high half. A value of 3 selects both halves and 0 selects neither.
- R5: Writing any nonzero value to the arm register (address 9) arms injection, and the register then reads 1. Writing zero disarms it. Reset leaves it disarmed. While disarmed, no transaction is altered.
- R6: When type bit 0 (repeat) is clear, arming clears itself on the first injection, and later matching writes pass clean.
- R7: When type bit 0 is set, every matching write is corrupted until the arm register is written with zero.
- R8: When type bit 2 is set, `out_par_err` is high together with the injected transaction. Parity corruption alone leaves the check bits unchanged.
- R9: An injection happens only if type bit 1 or bit 2 is set. Each injection raises `inj_pulse` for one cycle together with the transaction and increments the count register (address 10). A type word with neither bit set causes no injection and leaves arming unchanged.
- R10: Each input transaction appears at the outputs exactly one clock later, and `out_valid` follows `in_valid`. After reset, `out_valid` and `inj_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| in_valid | input | 1 | Transaction valid |
| in_write | input | 1 | Transaction is a write |
| in_dimm | input | DIMM_W | Module number within its channel |
| in_rank | input | RANK_W | Rank |
| in_chan | input | CHAN_W | Channel |
| in_bank | input | BANK_W | Bank |
| in_page | input | PAGE_W | Page |
| in_col | input | COL_W | Column |
| in_data | input | 2*DATA_W | Codeword data, both sections |
| in_chk | input | 2*CHK_W | Check bits, high half over low half |
| out_valid | output | 1 | Output transaction valid |
| out_data | output | 2*DATA_W | Data passed through unchanged |
| out_chk | output | 2*CHK_W | Check bits, possibly corrupted |
| out_par_err | output | 1 | Parity error injected on this transaction |
| inj_pulse | output | 1 | An injection happened on this transaction |

## Verification
A wrong match value or a stuck wildcard flag shows up on the next write to the affected location: a corrupted write appears where a clean one was expected, or the reverse. It can also be seen at once through register readback. If the arming bit fails to clear, the next matching write one clock later still carries flipped check bits and a pulse. A stale counter shows on the first read after any injection. Because every mismatch appears one cycle after the offending transaction, each test sends a transaction and then checks that cycle's output, the arm bit and the counter.

// File: rtl/inj_pkg.sv
package inj_pkg;
  localparam int NFLD    = 6;
  localparam int RADDR_W = 4;
  localparam int RDATA_W = 32;
  localparam int ANY_BIT = 31;

  typedef enum logic [RADDR_W-1:0] {
    RA_DIMM  = 4'd0,
    RA_RANK  = 4'd1,
    RA_CHAN  = 4'd2,
    RA_BANK  = 4'd3,
    RA_PAGE  = 4'd4,
    RA_COL   = 4'd5,
    RA_MASK  = 4'd6,
    RA_SECT  = 4'd7,
    RA_TYPE  = 4'd8,
    RA_ARM   = 4'd9,
    RA_COUNT = 4'd10
  } reg_addr_e;

  localparam int TYP_REPEAT = 0;
  localparam int TYP_ECC    = 1;
  localparam int TYP_PAR    = 2;

  function automatic int wider(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/inj_regs.sv
module inj_regs
  import inj_pkg::*;
#(
  parameter int FLD_W = 16,
  parameter int CHK_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [RADDR_W-1:0]               addr,
  input  logic [RDATA_W-1:0]               wdata,
  input  logic                             inject,
  output logic [NFLD-1:0][FLD_W-1:0]       fld_val,
  output logic [NFLD-1:0]                  fld_any,
  output logic [CHK_W-1:0]                 mask,
  output logic [1:0]                       sect,
  output logic [2:0]                       typ,
  output logic                             armed,
  output logic [CNT_W-1:0]                 cnt,
  output logic [RDATA_W-1:0]               rdata
);
  logic [NFLD-1:0][FLD_W-1:0] val_q, val_d;
  logic [NFLD-1:0]            any_q, any_d;
  logic [CHK_W-1:0]           mask_q, mask_d;
  logic [1:0]                 sect_q, sect_d;
  logic [2:0]                 typ_q, typ_d;
  logic                       arm_q, arm_d;
  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic                       wr_arm;

  assign wr_arm = we && (addr == RA_ARM);

  always_comb begin
    val_d  = val_q;
    any_d  = any_q;
    mask_d = mask_q;
    sect_d = sect_q;
    typ_d  = typ_q;
    for (int i = 0; i < NFLD; i++) begin
      if (we && (addr == RADDR_W'(i))) begin
        val_d[i] = wdata[FLD_W-1:0];
        any_d[i] = wdata[ANY_BIT];
      end
    end
    if (we && (addr == RA_MASK)) mask_d = wdata[CHK_W-1:0];
    if (we && (addr == RA_SECT)) sect_d = wdata[1:0];
    if (we && (addr == RA_TYPE)) typ_d  = wdata[2:0];
    // software write to the arm register wins over self-clearing
    if (wr_arm)                             arm_d = |wdata;
    else if (inject && !typ_q[TYP_REPEAT])  arm_d = 1'b0;
    else                                    arm_d = arm_q;
    cnt_d = inject ? cnt_q + CNT_W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      any_q  <= '1;
      mask_q <= '0;
      sect_q <= '0;
      typ_q  <= '0;
      arm_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (we) begin
        val_q  <= val_d;
        any_q  <= any_d;
        mask_q <= mask_d;
        sect_q <= sect_d;
        typ_q  <= typ_d;
      end
      if (wr_arm || inject) arm_q <= arm_d;
      if (inject)           cnt_q <= cnt_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NFLD; i++) begin
      if (addr == RADDR_W'(i)) begin
        rdata[FLD_W-1:0] = val_q[i];
        rdata[ANY_BIT]   = any_q[i];
      end
    end
    case (addr)
      RA_MASK:  rdata[CHK_W-1:0] = mask_q;
      RA_SECT:  rdata[1:0]       = sect_q;
      RA_TYPE:  rdata[2:0]       = typ_q;
      RA_ARM:   rdata[0]         = arm_q;
      RA_COUNT: rdata[CNT_W-1:0] = cnt_q;
      default:  ;
    endcase
  end

  assign fld_val = val_q;
  assign fld_any = any_q;
  assign mask    = mask_q;
  assign sect    = sect_q;
  assign typ     = typ_q;
  assign armed   = arm_q;
  assign cnt     = cnt_q;
endmodule

// File: rtl/inj_match.sv
module inj_match
  import inj_pkg::*;
#(
  parameter int FLD_W = 16
) (
  input  logic [NFLD-1:0][FLD_W-1:0] loc,
  input  logic [NFLD-1:0][FLD_W-1:0] fld_val,
  input  logic [NFLD-1:0]            fld_any,
  output logic                       hit
);
  logic [NFLD-1:0] fld_hit;

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    assign fld_hit[g] = fld_any[g] || (loc[g] == fld_val[g]);
  end

  assign hit = &fld_hit;
endmodule

// File: rtl/inj_corrupt.sv
module inj_corrupt
  import inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2*DATA_W-1:0] in_data,
  input  logic [2*CHK_W-1:0]  in_chk,
  input  logic                fire,
  input  logic                ecc_en,
  input  logic                par_en,
  input  logic [1:0]          sect,
  input  logic [CHK_W-1:0]    mask,
  output logic                out_valid,
  output logic [2*DATA_W-1:0] out_data,
  output logic [2*CHK_W-1:0]  out_chk,
  output logic                out_par_err,
  output logic                inj_pulse
);
  logic [2*CHK_W-1:0]  flip;
  logic                vld_q, vld_d;
  logic [2*DATA_W-1:0] dat_q, dat_d;
  logic [2*CHK_W-1:0]  chk_q, chk_d;
  logic                par_q, par_d;
  logic                pls_q, pls_d;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign flip[h*CHK_W +: CHK_W] = (fire && ecc_en && sect[h]) ? mask : '0;
  end

  always_comb begin
    vld_d = in_valid;
    dat_d = in_data;
    chk_d = in_chk ^ flip;
    par_d = fire && par_en;
    pls_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      chk_q <= '0;
      par_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      par_q <= par_d;
      pls_q <= pls_d;
      if (in_valid) begin
        dat_q <= dat_d;
        chk_q <= chk_d;
      end
    end
  end

  assign out_valid   = vld_q;
  assign out_data    = dat_q;
  assign out_chk     = chk_q;
  assign out_par_err = par_q;
  assign inj_pulse   = pls_q;
endmodule

// File: rtl/wr_fault_injector.sv
module wr_fault_injector
  import inj_pkg::*;
#(
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 11,
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [3:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                in_valid,
  input  logic                in_write,
  input  logic [DIMM_W-1:0]   in_dimm,
  input  logic [RANK_W-1:0]   in_rank,
  input  logic [CHAN_W-1:0]   in_chan,
  input  logic [BANK_W-1:0]   in_bank,
  input  logic [PAGE_W-1:0]   in_page,
  input  logic [COL_W-1:0]    in_col,
  input  logic [2*DATA_W-1:0] in_data,
  input  logic [2*CHK_W-1:0]  in_chk,
  output logic                out_valid,
  output logic [2*DATA_W-1:0] out_data,
  output logic [2*CHK_W-1:0]  out_chk,
  output logic                out_par_err,
  output logic                inj_pulse
);
  localparam int FLD_W = wider(wider(wider(DIMM_W, RANK_W), wider(CHAN_W, BANK_W)),
                               wider(PAGE_W, COL_W));

  logic                       rst_m, rst_q;
  logic [NFLD-1:0][FLD_W-1:0] loc;
  logic [NFLD-1:0][FLD_W-1:0] fld_val;
  logic [NFLD-1:0]            fld_any;
  logic [CHK_W-1:0]           mask;
  logic [1:0]                 sect;
  logic [2:0]                 typ;
  logic                       armed;
  logic [CNT_W-1:0]           cnt;
  logic                       hit;
  logic                       fire;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  assign loc[0] = FLD_W'(in_dimm);
  assign loc[1] = FLD_W'(in_rank);
  assign loc[2] = FLD_W'(in_chan);
  assign loc[3] = FLD_W'(in_bank);
  assign loc[4] = FLD_W'(in_page);
  assign loc[5] = FLD_W'(in_col);

  inj_regs #(.FLD_W(FLD_W), .CHK_W(CHK_W), .CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_q),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .inject  (fire),
    .fld_val (fld_val),
    .fld_any (fld_any),
    .mask    (mask),
    .sect    (sect),
    .typ     (typ),
    .armed   (armed),
    .cnt     (cnt),
    .rdata   (reg_rdata)
  );

  inj_match #(.FLD_W(FLD_W)) u_match (
    .loc     (loc),
    .fld_val (fld_val),
    .fld_any (fld_any),
    .hit     (hit)
  );

  assign fire = armed && in_valid && in_write && hit && (typ[TYP_ECC] || typ[TYP_PAR]);

  inj_corrupt #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_corrupt (
    .clk         (clk),
    .rst_n       (rst_q),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_chk      (in_chk),
    .fire        (fire),
    .ecc_en      (typ[TYP_ECC]),
    .par_en      (typ[TYP_PAR]),
    .sect        (sect),
    .mask        (mask),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_chk     (out_chk),
    .out_par_err (out_par_err),
    .inj_pulse   (inj_pulse)
  );
endmodule

// File: rtl/inj_checker.sv
module inj_checker
  import inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int CNT_W  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic [3:0]          reg_addr,
  input logic                in_valid,
  input logic                in_write,
  input logic [2*DATA_W-1:0] in_data,
  input logic [2*CHK_W-1:0]  in_chk,
  input logic                out_valid,
  input logic [2*DATA_W-1:0] out_data,
  input logic [2*CHK_W-1:0]  out_chk,
  input logic                out_par_err,
  input logic                inj_pulse,
  input logic                armed,
  input logic [2:0]          cfg_typ,
  input logic [CNT_W-1:0]    inj_cnt
);
  assert_pulse_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inj_pulse |-> $past(in_valid && in_write));

  assert_data_intact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data == $past(in_data));

  assert_clean_without_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !inj_pulse) |-> out_chk == $past(in_chk));

  assert_oneshot_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_pulse && !$past(cfg_typ[TYP_REPEAT]) && !$past(reg_we && reg_addr == RA_ARM))
      |-> !armed);

  assert_parity_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_par_err |-> inj_pulse);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inj_pulse |-> inj_cnt == $past(inj_cnt) + CNT_W'(1));

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));
endmodule

bind wr_fault_injector inj_checker #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CNT_W(CNT_W)) u_inj_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .in_valid    (in_valid),
  .in_write    (in_write),
  .in_data     (in_data),
  .in_chk      (in_chk),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_chk     (out_chk),
  .out_par_err (out_par_err),
  .inj_pulse   (inj_pulse),
  .armed       (armed),
  .cfg_typ     (typ),
  .inj_cnt     (cnt)
);

// File: tb/test_wr_fault_injector.sv
`timescale 1ns/1ps
module test_wr_fault_injector;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_we;
  logic [3:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         in_valid, in_write;
  logic [1:0]   in_dimm, in_rank, in_chan;
  logic [2:0]   in_bank;
  logic [15:0]  in_page;
  logic [10:0]  in_col;
  logic [127:0] in_data;
  logic [15:0]  in_chk;
  logic         out_valid;
  logic [127:0] out_data;
  logic [15:0]  out_chk;
  logic         out_par_err, inj_pulse;

  int n_run = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  localparam logic [127:0] DPAT = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [15:0]  CPAT = 16'hA55A;

  always #2 clk = ~clk;

  wr_fault_injector i_wr_fault_injector (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_write(in_write), .in_dimm(in_dimm), .in_rank(in_rank), .in_chan(in_chan),
    .in_bank(in_bank), .in_page(in_page), .in_col(in_col), .in_data(in_data),
    .in_chk(in_chk), .out_valid(out_valid), .out_data(out_data), .out_chk(out_chk),
    .out_par_err(out_par_err), .inj_pulse(inj_pulse)
  );

  typedef struct packed {
    logic       r_any;  logic [1:0] r_val;
    logic       b_any;  logic [2:0] b_val;
    logic [7:0] mask;   logic [1:0] sect;  logic [2:0] typ;
    logic [1:0] l_rank; logic [2:0] l_bank; logic wr;
    logic [7:0] x_lo;   logic [7:0] x_hi;  logic par; logic pulse;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{1'b1, 2'd0, 1'b1, 3'd0, 8'h40, 2'd1, 3'd2, 2'd0, 3'd0, 1'b1, 8'h40, 8'h00, 1'b0, 1'b1},
    '{1'b0, 2'd2, 1'b1, 3'd0, 8'h03, 2'd2, 3'd2, 2'd2, 3'd5, 1'b1, 8'h00, 8'h03, 1'b0, 1'b1},
    '{1'b0, 2'd2, 1'b0, 3'd5, 8'h81, 2'd3, 3'd2, 2'd2, 3'd4, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0},
    '{1'b0, 2'd2, 1'b0, 3'd5, 8'h81, 2'd3, 3'd2, 2'd2, 3'd5, 1'b1, 8'h81, 8'h81, 1'b0, 1'b1},
    '{1'b0, 2'd1, 1'b1, 3'd0, 8'hFF, 2'd3, 3'd2, 2'd1, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0},
    '{1'b1, 2'd0, 1'b1, 3'd0, 8'h0F, 2'd1, 3'd4, 2'd3, 3'd7, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1},
    '{1'b1, 2'd0, 1'b1, 3'd0, 8'h10, 2'd2, 3'd6, 2'd0, 3'd1, 1'b1, 8'h00, 8'h10, 1'b1, 1'b1},
    '{1'b1, 2'd0, 1'b1, 3'd0, 8'h20, 2'd3, 3'd1, 2'd0, 3'd1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    check(tag, 128'(reg_rdata), 128'(exp));
  endtask

  // drive one transaction, sample its output one clock later
  task automatic send(input logic [1:0] d, input logic [1:0] r, input logic [1:0] c,
                      input logic [2:0] b, input logic [15:0] p, input logic [10:0] col,
                      input logic w);
    in_dimm = d; in_rank = r; in_chan = c; in_bank = b; in_page = p; in_col = col;
    in_write = w; in_valid = 1'b1; in_data = DPAT; in_chk = CPAT;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input logic [15:0] xr, input logic par, input logic pls,
                            input string tag);
    check({tag, " valid"}, 128'(out_valid), 128'(1'b1));
    check({tag, " data"},  out_data, DPAT);
    check({tag, " chk"},   128'(out_chk), 128'(CPAT ^ xr));
    check({tag, " par"},   128'(out_par_err), 128'(par));
    check({tag, " pulse"}, 128'(inj_pulse), 128'(pls));
    if (pls) exp_cnt++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    in_valid = 1'b0; in_write = 1'b0; in_dimm = '0; in_rank = '0; in_chan = '0;
    in_bank = '0; in_page = '0; in_col = '0; in_data = '0; in_chk = '0;
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // reset state: R2, R5, R9, R10
    for (int i = 0; i < 6; i++) rd_reg(4'(i), 32'h8000_0000, "R2 reset wildcard");
    rd_reg(4'd9,  32'd0, "R5 reset disarmed");
    rd_reg(4'd10, 32'd0, "R9 reset count");
    check("R10 reset out_valid", 128'(out_valid), 128'(1'b0));
    check("R10 reset pulse", 128'(inj_pulse), 128'(1'b0));

    // vector table: R1 R3 R4 R6 R8 R9
    foreach (VT[i]) begin
      wr_reg(4'd1, {VT[i].r_any, 29'd0, VT[i].r_val});
      wr_reg(4'd3, {VT[i].b_any, 28'd0, VT[i].b_val});
      wr_reg(4'd6, 32'(VT[i].mask));
      wr_reg(4'd7, 32'(VT[i].sect));
      wr_reg(4'd8, 32'(VT[i].typ));
      wr_reg(4'd9, 32'd1);
      send(2'd1, VT[i].l_rank, 2'd0, VT[i].l_bank, 16'h0042, 11'd7, VT[i].wr);
      expect_out({VT[i].x_hi, VT[i].x_lo}, VT[i].par, VT[i].pulse,
                 $sformatf("R1/R3/R4/R8 vec%0d", i));
      rd_reg(4'd9, 32'(!(VT[i].pulse && !VT[i].typ[0])), $sformatf("R6/R9 arm vec%0d", i));
      rd_reg(4'd10, 32'(exp_cnt), $sformatf("R9 count vec%0d", i));
      wr_reg(4'd9, 32'd0);
    end

    // field storage: R2
    wr_reg(4'd1, 32'h8000_0000);
    wr_reg(4'd3, 32'h8000_0000);
    wr_reg(4'd4, 32'h0000_1234);
    rd_reg(4'd4, 32'h0000_1234, "R2 numeric value clears wildcard");
    wr_reg(4'd5, 32'h8000_0005);
    rd_reg(4'd5, 32'h8000_0005, "R2 wildcard keeps value");

    // page match and one-shot: R1, R6
    wr_reg(4'd6, 32'h01); wr_reg(4'd7, 32'd1); wr_reg(4'd8, 32'd2); wr_reg(4'd9, 32'd1);
    send(2'd0, 2'd0, 2'd0, 3'd0, 16'h1235, 11'd3, 1'b1);
    expect_out(16'h0000, 1'b0, 1'b0, "R1 page mismatch");
    send(2'd0, 2'd0, 2'd0, 3'd0, 16'h1234, 11'd3, 1'b1);
    expect_out(16'h0001, 1'b0, 1'b1, "R1 page match");
    rd_reg(4'd9, 32'd0, "R6 one-shot disarms");
    send(2'd0, 2'd0, 2'd0, 3'd0, 16'h1234, 11'd3, 1'b1);
    expect_out(16'h0000, 1'b0, 1'b0, "R6 second write clean");

    // module and channel fields, nonzero arm value: R1, R5
    wr_reg(4'd0, 32'd3); wr_reg(4'd2, 32'd1);
    wr_reg(4'd9, 32'h0000_0100);
    rd_reg(4'd9, 32'd1, "R5 nonzero arms");
    send(2'd3, 2'd0, 2'd0, 3'd0, 16'h1234, 11'd0, 1'b1);
    expect_out(16'h0000, 1'b0, 1'b0, "R1 channel mismatch");
    send(2'd2, 2'd0, 2'd1, 3'd0, 16'h1234, 11'd0, 1'b1);
    expect_out(16'h0000, 1'b0, 1'b0, "R1 module mismatch");
    send(2'd3, 2'd0, 2'd1, 3'd0, 16'h1234, 11'd0, 1'b1);
    expect_out(16'h0001, 1'b0, 1'b1, "R1 all fields match");

    // repeat mode: R7, R5
    wr_reg(4'd6, 32'h80); wr_reg(4'd7, 32'd3); wr_reg(4'd8, 32'd3); wr_reg(4'd9, 32'd1);
    for (int k = 0; k < 3; k++) begin
      send(2'd3, 2'd2, 2'd1, 3'd6, 16'h1234, 11'd9, 1'b1);
      expect_out(16'h8080, 1'b0, 1'b1, $sformatf("R7 repeat write %0d", k));
    end
    rd_reg(4'd9, 32'd1, "R7 still armed");
    wr_reg(4'd9, 32'd0);
    send(2'd3, 2'd2, 2'd1, 3'd6, 16'h1234, 11'd9, 1'b1);
    expect_out(16'h0000, 1'b0, 1'b0, "R5 disarmed write clean");
    rd_reg(4'd10, 32'(exp_cnt), "R9 final count");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule